// File: doc/BRIEF.md
# Burst Column Sequencer for a Synchronous DRAM

This block supplies the column address for each data beat of a synchronous DRAM column burst. A one-cycle start request carries the first column and the direction of the transfer. The current mode settings select the burst length, the ordering and whether writes are cut to a single beat. From the next cycle on, the block presents one column per cycle, together with a valid flag and a flag that marks the final beat.

The address moves through the burst in one of two orders. The sequential order counts upward and wraps inside the aligned group of columns that the burst length spans. The interleaved order XORs the beat number into the low bits of the start column. A full-page setting cycles through all 256 columns until it is told to stop. Any burst can be ended early by a terminate input, or replaced by a new start request. A registered clock-enable freezes the whole sequence for one cycle after each low sample, which mirrors a suspended internal clock.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and after it is released, `beat_valid` and `beat_last` are 0 and `beat_col` is 0.
- R2: A start accepted at a clock edge makes `beat_valid` 1 after that edge, with `beat_col` equal to `start_col`.
- R3: Burst length codes `bl_code` 3'b000, 3'b001, 3'b010 and 3'b011 give 1, 2, 4 and 8 beats. `beat_valid` goes low in the cycle after the final beat.
- R4: With `ilv_mode` = 0 (sequential), beat i is (start + i) mod L inside the aligned group of L columns that holds the start column. Example: start 5 with L = 8 gives 5,6,7,0,1,2,3,4.
- R5: With `ilv_mode` = 1 (interleaved), beat i is the start column XOR i. Example: start 5 with L = 8 gives 5,4,7,6,1,0,3,2.
- R6: Code 3'b111 with sequential order is full page. Beat i is (start + i) mod 256, `beat_last` never rises, and the burst runs until it is terminated.
- R7: The reserved codes 3'b100, 3'b101 and 3'b110 give a single beat. Code 3'b111 with interleaved order also gives a single beat.
- R8: With `wr_single` = 1, a write burst (`start_wr` = 1) has one beat whatever the code. A read burst still uses the coded length.
- R9: A start during a running burst restarts the sequence from the new start column with the new settings.
- R10: `stop` without `start` makes `beat_valid` 0 after the edge. When `start` and `stop` are high together, the start wins.
- R11: When `cke` was low at the previous edge, the current edge changes no output, and a `start` at that edge is ignored.
- R12: `beat_last` is 1 only together with `beat_valid`, and only on the final beat of a burst that is not full page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; a low sample suspends the following edge |
| start | input | 1 | Begin a burst (a read or write column command) |
| start_col | input | 8 | First column of the burst |
| start_wr | input | 1 | 1 when the burst is a write |
| bl_code | input | 3 | Burst length code |
| ilv_mode | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| wr_single | input | 1 | Limits write bursts to one beat |
| stop | input | 1 | Ends the running burst (terminate or precharge) |
| beat_col | output | 8 | Column of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | Final beat of a burst that is not full page |

## Verification
The hardest state to reach from the ports is a suspended edge that meets a new start request in the middle of a burst. The clock-enable acts one edge late, so the bench lowers it one cycle ahead, then raises start exactly on the frozen edge and confirms that the column neither moves nor reloads. Interruption by a new start also has to land while an earlier burst is partway through. A full-page burst is run past the 256-column wrap before it is stopped, so the wrap point and the missing last flag are both observed.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    localparam int unsigned COLW = 8;

    typedef logic [COLW-1:0] col_t;

    typedef enum logic [2:0] {
        BLC_ONE   = 3'b000,
        BLC_TWO   = 3'b001,
        BLC_FOUR  = 3'b010,
        BLC_EIGHT = 3'b011,
        BLC_PAGE  = 3'b111
    } blc_e;

    typedef struct packed {
        logic valid;
        logic last;
        logic full;
        logic ilv;
        col_t span;
        col_t base;
        col_t beat;
        logic run;
    } seq_t;

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
    import colgen_pkg::*;
(
    input  logic [2:0] code,
    input  logic       ilv,
    input  logic       is_wr,
    input  logic       wr_one,
    output col_t       span_m1,
    output logic       full
);

    always_comb begin
        span_m1 = '0;
        full    = 1'b0;
        unique case (code)
            BLC_ONE:   span_m1 = col_t'(0);
            BLC_TWO:   span_m1 = col_t'(1);
            BLC_FOUR:  span_m1 = col_t'(3);
            BLC_EIGHT: span_m1 = col_t'(7);
            BLC_PAGE: begin
                if (!ilv) begin
                    span_m1 = '1;
                    full    = 1'b1;
                end
            end
            default:   span_m1 = '0;
        endcase
        if (is_wr && wr_one) begin
            span_m1 = '0;
            full    = 1'b0;
        end
    end

endmodule

// File: rtl/colgen_order.sv
module colgen_order
    import colgen_pkg::*;
(
    input  col_t base,
    input  col_t beat,
    input  col_t span_m1,
    input  logic ilv,
    output col_t col
);

    col_t seq_col;
    col_t xor_col;

    always_comb begin
        seq_col = (base & ~span_m1) | ((base + beat) & span_m1);
        xor_col = base ^ (beat & span_m1);
        col     = ilv ? xor_col : seq_col;
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  logic       start,
    input  logic [7:0] start_col,
    input  logic       start_wr,
    input  logic [2:0] bl_code,
    input  logic       ilv_mode,
    input  logic       wr_single,
    input  logic       stop,
    output logic [7:0] beat_col,
    output logic       beat_valid,
    output logic       beat_last
);

    localparam seq_t SEQ_RST = '{valid: 1'b0, last: 1'b0, full: 1'b0, ilv: 1'b0,
                                 span: '0, base: '0, beat: '0, run: 1'b1};

    seq_t seq_d, seq_q;
    col_t dec_span;
    logic dec_full;
    col_t beat_nxt;

    colgen_mode_dec u_dec (
        .code    (bl_code),
        .ilv     (ilv_mode),
        .is_wr   (start_wr),
        .wr_one  (wr_single),
        .span_m1 (dec_span),
        .full    (dec_full)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.run = cke;
        beat_nxt  = seq_q.beat + col_t'(1);
        if (seq_q.run) begin
            if (start) begin
                seq_d.valid = 1'b1;
                seq_d.base  = start_col;
                seq_d.beat  = '0;
                seq_d.span  = dec_span;
                seq_d.full  = dec_full;
                seq_d.ilv   = ilv_mode;
                seq_d.last  = !dec_full && (dec_span == '0);
            end else if (stop) begin
                seq_d.valid = 1'b0;
                seq_d.last  = 1'b0;
            end else if (seq_q.valid) begin
                if (seq_q.last) begin
                    seq_d.valid = 1'b0;
                    seq_d.last  = 1'b0;
                end else begin
                    seq_d.beat = beat_nxt;
                    seq_d.last = !seq_q.full && (beat_nxt == seq_q.span);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    colgen_order u_order (
        .base    (seq_q.base),
        .beat    (seq_q.beat),
        .span_m1 (seq_q.span),
        .ilv     (seq_q.ilv),
        .col     (beat_col)
    );

    assign beat_valid = seq_q.valid;
    assign beat_last  = seq_q.last;

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       start,
    input logic       stop,
    input logic [7:0] start_col,
    input logic [7:0] beat_col,
    input logic       beat_valid,
    input logic       beat_last
);

    // R12
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && $past(cke)) |=> (beat_valid && beat_col == $past(start_col)));

    // R3
    end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !start && $past(cke)) |=> !beat_valid);

    // R10
    stop_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start && $past(cke)) |=> !beat_valid);

    // R11
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cke) |=> ($stable(beat_col) && $stable(beat_valid) && $stable(beat_last)));

endmodule

bind sdram_burst_colgen colgen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .start      (start),
    .stop       (stop),
    .start_col  (start_col),
    .beat_col   (beat_col),
    .beat_valid (beat_valid),
    .beat_last  (beat_last)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic       start_wr = 1'b0;
    logic [2:0] bl_code = '0;
    logic       ilv_mode = 1'b0;
    logic       wr_single = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] beat_col;
    logic       beat_valid;
    logic       beat_last;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sdram_burst_colgen u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .start(start), .start_col(start_col),
        .start_wr(start_wr), .bl_code(bl_code), .ilv_mode(ilv_mode),
        .wr_single(wr_single), .stop(stop), .beat_col(beat_col),
        .beat_valid(beat_valid), .beat_last(beat_last)
    );

    // {code[2:0], ilv, write, wr_single, start[7:0], beats[3:0]}
    localparam int NV = 13;
    localparam logic [17:0] VEC [NV] = '{
        {3'b000, 1'b0, 1'b0, 1'b0, 8'h2A, 4'd1},
        {3'b001, 1'b0, 1'b0, 1'b0, 8'h13, 4'd2},
        {3'b010, 1'b0, 1'b0, 1'b0, 8'h45, 4'd4},
        {3'b011, 1'b0, 1'b0, 1'b0, 8'h05, 4'd8},
        {3'b011, 1'b1, 1'b0, 1'b0, 8'h05, 4'd8},
        {3'b010, 1'b1, 1'b0, 1'b0, 8'hA2, 4'd4},
        {3'b001, 1'b1, 1'b1, 1'b0, 8'h7F, 4'd2},
        {3'b011, 1'b0, 1'b1, 1'b1, 8'h33, 4'd1},
        {3'b011, 1'b0, 1'b0, 1'b1, 8'h33, 4'd8},
        {3'b100, 1'b0, 1'b0, 1'b0, 8'h10, 4'd1},
        {3'b110, 1'b1, 1'b0, 1'b0, 8'hC7, 4'd1},
        {3'b111, 1'b1, 1'b0, 1'b0, 8'h09, 4'd1},
        {3'b101, 1'b0, 1'b1, 1'b0, 8'hFE, 4'd1}
    };

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic chk(string tag, logic [7:0] col_e, logic v_e, logic l_e);
        logic ok;
        n_chk++;
        ok = (beat_valid === v_e) && (beat_last === l_e) && (!v_e || beat_col === col_e);
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: col=%02h valid=%0b last=%0b expected col=%02h valid=%0b last=%0b",
                     tag, beat_col, beat_valid, beat_last, col_e, v_e, l_e);
        end
    endtask

    function automatic logic [7:0] seq_exp(logic [7:0] s, int len, int i);
        int off;
        off = int'(s) % len;
        return 8'((int'(s) - off) + ((off + i) % len));
    endfunction

    task automatic launch(logic [2:0] code, logic ilv, logic wr, logic ws, logic [7:0] s);
        bl_code = code; ilv_mode = ilv; start_wr = wr; wr_single = ws; start_col = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_up();
    end

    initial begin
        @(negedge clk);
        chk("R1 in reset", 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 8'h00, 1'b0, 1'b0);
        if (beat_col !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 col: col=%02h expected col=00", beat_col);
        end
        n_chk++;

        for (int v = 0; v < NV; v++) begin
            logic [2:0] code;
            logic       ilv, wr, ws;
            logic [7:0] s;
            int         len;
            string      tag;
            {code, ilv, wr, ws, s} = VEC[v][17:4];
            len = int'(VEC[v][3:0]);
            if (code[2] && !(code == 3'b111 && !ilv)) tag = "R7";
            else if (wr && ws) tag = "R8";
            else if (ws) tag = "R8 read";
            else if (ilv) tag = "R5";
            else tag = "R4";
            launch(code, ilv, wr, ws, s);
            for (int i = 0; i < len; i++) begin
                logic [7:0] e;
                e = ilv ? (s ^ 8'(i)) : seq_exp(s, len, i);
                chk(tag, e, 1'b1, (i == len - 1));
                @(negedge clk);
            end
            chk("R3 end of burst", 8'h00, 1'b0, 1'b0);
        end

        // R9: restart in the middle of an 8-beat burst
        launch(3'b011, 1'b0, 1'b0, 1'b0, 8'h20);
        chk("R2 first beat", 8'h20, 1'b1, 1'b0);
        @(negedge clk);
        chk("R9 before restart", 8'h21, 1'b1, 1'b0);
        launch(3'b010, 1'b0, 1'b0, 1'b0, 8'h64);
        chk("R9 restart", 8'h64, 1'b1, 1'b0);
        @(negedge clk); chk("R9", 8'h65, 1'b1, 1'b0);
        @(negedge clk); chk("R9", 8'h66, 1'b1, 1'b0);
        @(negedge clk); chk("R9 last", 8'h67, 1'b1, 1'b1);
        @(negedge clk); chk("R9 end", 8'h00, 1'b0, 1'b0);

        // R10: stop ends a burst; start beats stop
        launch(3'b011, 1'b0, 1'b0, 1'b0, 8'h40);
        chk("R10 first", 8'h40, 1'b1, 1'b0);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R10 stopped", 8'h00, 1'b0, 1'b0);
        stop = 1'b1;
        launch(3'b001, 1'b0, 1'b0, 1'b0, 8'h50);
        stop = 1'b0;
        chk("R10 start wins", 8'h50, 1'b1, 1'b0);
        @(negedge clk); chk("R10", 8'h51, 1'b1, 1'b1);
        @(negedge clk); chk("R10 end", 8'h00, 1'b0, 1'b0);

        // R11: suspend freezes the sequence and ignores start
        launch(3'b010, 1'b0, 1'b0, 1'b0, 8'h10);
        chk("R11 first", 8'h10, 1'b1, 1'b0);
        cke = 1'b0;
        @(negedge clk);
        chk("R11 one edge still runs", 8'h11, 1'b1, 1'b0);
        cke = 1'b1;
        launch(3'b000, 1'b1, 1'b0, 1'b0, 8'h99);
        chk("R11 held, start ignored", 8'h11, 1'b1, 1'b0);
        @(negedge clk); chk("R11 resumed", 8'h12, 1'b1, 1'b0);
        @(negedge clk); chk("R11 last", 8'h13, 1'b1, 1'b1);
        @(negedge clk); chk("R11 end", 8'h00, 1'b0, 1'b0);

        // R6: full page wraps at 256 and runs until stopped
        launch(3'b111, 1'b0, 1'b0, 1'b0, 8'hFD);
        for (int i = 0; i < 260; i++) begin
            chk("R6", 8'((253 + i) % 256), 1'b1, 1'b0);
            @(negedge clk);
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R6 stopped", 8'h00, 1'b0, 1'b0);

        finish_up();
    end

endmodule